// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading a four-level radix tree of translation tables from memory. A client hands over one virtual address at a time, together with the base of the top-level table. The walker then reads one 64-bit entry per level over a simple memory read port, and waits as long as memory takes to answer. Each table is 4 KB in size, 4 KB aligned, and holds 512 eight-byte entries.

The walk normally ends at the last level with a 4 KB page. A third-level entry may instead map a 1 GB page, and a second-level entry may map a 2 MB page. In those cases the walk stops early and keeps more of the virtual address as page offset. A missing entry at any level ends the walk with a fault that names the level. A virtual address whose upper bits are not a sign extension of bit 47 faults without touching memory. Each result appears for a single cycle on a done strobe. The result carries the physical address, a size code and the fault status.

Top module: `radix_walk`

## Requirements
- R1: After reset `req_ready` is high. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance up to and including the done cycle, and it is high again in the cycle after done. `req_valid` has no effect while `req_ready` is low.
- R2: The table indices are taken from virtual address bits 47:39 (top level), 38:30 (third level), 29:21 (second level) and 20:12 (last level). Bits 11:0 are the 4 KB page offset.
- R3: Each entry read goes to an address formed from bits 51:12 of the current table base with the 9-bit index times 8 added. The top-level base is `root_base`, and its bits 11:0 are ignored. `mem_req_valid` is high for exactly one cycle per read. Reads follow the walk order, with no new read until the previous response has arrived.
- R4: The walker waits any number of cycles for `mem_rsp_valid`. A `mem_rsp_valid` that arrives while no read is outstanding is ignored.
- R5: Entry bit 0 is the present flag. If it is clear, the walk ends with `done_fault`=1 and `done_level` set to the level of that entry. The level codes are 3 for top, 2 for third, 1 for second and 0 for last.
- R6: A present third-level entry with bit 7 set ends the walk with a 1 GB page. The result has `done_size`=2, `done_level`=2, and `done_paddr` = {entry[51:30], va[29:0]}.
- R7: A present second-level entry with bit 7 set ends the walk with a 2 MB page. The result has `done_size`=1, `done_level`=1, and `done_paddr` = {entry[51:21], va[20:0]}.
- R8: A present last-level entry ends the walk with a 4 KB page. The result has `done_size`=0, `done_level`=0, and `done_paddr` = {entry[51:12], va[11:0]}. Bit 7 is ignored in top-level and last-level entries, and entry bits 63:52 never reach an address.
- R9: If va[63:48] is not all copies of va[47], no memory read is issued. In that case `done` rises in the cycle after acceptance with `done_fault`=1, `done_noncanon`=1 and `done_level`=3.
- R10: `done` is a one-cycle pulse per accepted request. On any fault, `done_paddr` and `done_size` are 0. `done_noncanon` is 1 only for the address check of R9.
- R11: While reset is asserted and after it is released, `done` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| root_base | input | 52 | Physical base of the top-level table, sampled at acceptance |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| done | output | 1 | One-cycle result strobe |
| done_paddr | output | 52 | Translated physical address |
| done_size | output | 2 | Page size code: 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| done_fault | output | 1 | Walk ended in a fault |
| done_noncanon | output | 1 | Fault came from the upper-address check |
| done_level | output | 2 | Level at which the walk ended |

## Verification
The bench uses the default parameters: a 48-bit virtual address, a 52-bit physical address, 9-bit indices, a 12-bit offset and four levels. With these values, each walk depth can be reached through a sparse table set held in an associative memory, and the bench places each fault level and each leaf size separately. Response latencies from zero to several idle cycles, stray response strobes, and requests held asserted during a walk bring the waiting and ignore rules within reach. Sign-extended upper-half addresses, and entries that carry bits outside the frame field, exercise the address checks and the field masking.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_ISSUE = 2'd1,
      WK_WAIT  = 2'd2,
      WK_DONE  = 2'd3
   } walk_state_e;

   typedef struct packed {
      logic fault;
      logic noncanon;
   } walk_flags_t;

endpackage

// File: rtl/rw_addr_form.sv
module rw_addr_form #(
   parameter int VA_W   = 48,
   parameter int PA_W   = 52,
   parameter int IDX_W  = 9,
   parameter int OFS_W  = 12,
   parameter int LEVELS = 4,
   parameter int ENT_SH = 3,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] level,
   input  logic [PA_W-1:0]  tbase,
   output logic [PA_W-1:0]  ent_addr
);

   logic [IDX_W-1:0] idx_a [LEVELS];
   logic [IDX_W-1:0] idx_sel;
   logic             unused_ab;

   for (genvar g = 0; g < LEVELS; g++) begin : g_idx
      assign idx_a[g] = vaddr[OFS_W + g*IDX_W +: IDX_W];
   end

   assign idx_sel   = idx_a[level];
   assign ent_addr  = {tbase[PA_W-1:OFS_W], idx_sel, {ENT_SH{1'b0}}};
   assign unused_ab = ^{tbase[OFS_W-1:0], vaddr[OFS_W-1:0]};

endmodule

// File: rtl/rw_entry_dec.sv
module rw_entry_dec #(
   parameter int ENT_W     = 64,
   parameter int PA_W      = 52,
   parameter int OFS_W     = 12,
   parameter int LEVELS    = 4,
   parameter int PRES_BIT  = 0,
   parameter int LARGE_BIT = 7,
   parameter bit LARGE_EN  = 1'b1,
   parameter int LARGE_LO  = 1,
   parameter int LARGE_HI  = 2,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [LVL_W-1:0] level,
   output logic             present,
   output logic             leaf,
   output logic [PA_W-1:0]  next_base
);

   logic large_hit;
   logic unused_ed;

   if (LARGE_EN) begin : g_large
      assign large_hit = entry[LARGE_BIT]
                         && (level >= LVL_W'(LARGE_LO))
                         && (level <= LVL_W'(LARGE_HI));
   end else begin : g_nolarge
      assign large_hit = 1'b0;
   end

   assign present   = entry[PRES_BIT];
   assign leaf      = (level == '0) || large_hit;
   assign next_base = {entry[PA_W-1:OFS_W], {OFS_W{1'b0}}};
   assign unused_ed = ^entry;

endmodule

// File: rtl/rw_phys_form.sv
module rw_phys_form #(
   parameter int ENT_W  = 64,
   parameter int VA_W   = 48,
   parameter int PA_W   = 52,
   parameter int IDX_W  = 9,
   parameter int OFS_W  = 12,
   parameter int LEVELS = 4,
   localparam int LVL_W = $clog2(LEVELS)
) (
   input  logic [ENT_W-1:0] entry,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] level,
   output logic [PA_W-1:0]  paddr
);

   logic [PA_W-1:0] pa_c [LEVELS];
   logic            unused_pf;

   for (genvar g = 0; g < LEVELS; g++) begin : g_cand
      localparam int SH = OFS_W + g*IDX_W;
      assign pa_c[g] = {entry[PA_W-1:SH], vaddr[SH-1:0]};
   end

   assign paddr     = pa_c[level];
   assign unused_pf = ^{entry, vaddr};

endmodule

// File: rtl/radix_walk.sv
module radix_walk
   import radix_walk_pkg::*;
#(
   parameter int VA_IN_W   = 64,
   parameter int VA_W      = 48,
   parameter int PA_W      = 52,
   parameter int IDX_W     = 9,
   parameter int OFS_W     = 12,
   parameter int LEVELS    = 4,
   parameter int ENT_W     = 64,
   parameter int PRES_BIT  = 0,
   parameter int LARGE_BIT = 7,
   localparam int LVL_W    = $clog2(LEVELS),
   localparam int ENT_SH   = $clog2(ENT_W/8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_IN_W-1:0] req_vaddr,
   input  logic [PA_W-1:0]    root_base,
   output logic               mem_req_valid,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENT_W-1:0]   mem_rsp_data,
   output logic               done,
   output logic [PA_W-1:0]    done_paddr,
   output logic [LVL_W-1:0]   done_size,
   output logic               done_fault,
   output logic               done_noncanon,
   output logic [LVL_W-1:0]   done_level
);

   if (VA_W != OFS_W + LEVELS*IDX_W) begin : g_chk_va
      $error("virtual width must equal offset plus all index fields");
   end
   if (IDX_W + ENT_SH != OFS_W) begin : g_chk_tbl
      $error("a table must fill exactly one page");
   end
   if (PA_W > ENT_W || PA_W <= OFS_W + (LEVELS-1)*IDX_W) begin : g_chk_pa
      $error("physical width out of range");
   end
   if (LARGE_BIT >= OFS_W || PRES_BIT >= OFS_W) begin : g_chk_flag
      $error("flag bits must sit below the frame field");
   end

   localparam int HI_W = VA_IN_W - VA_W + 1;

   walk_state_e      st_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PA_W-1:0]  base_q;
   logic [VA_W-1:0]  va_q;
   logic [PA_W-1:0]  res_pa_q;
   logic [LVL_W-1:0] res_size_q;
   logic [LVL_W-1:0] res_lvl_q;
   walk_flags_t      res_flg_q;

   logic [HI_W-1:0]  va_hi;
   logic             noncanon;
   logic [PA_W-1:0]  ent_addr;
   logic             ent_present;
   logic             ent_leaf;
   logic [PA_W-1:0]  ent_next;
   logic [PA_W-1:0]  leaf_pa;

   assign va_hi    = req_vaddr[VA_IN_W-1:VA_W-1];
   assign noncanon = !((&va_hi) || !(|va_hi));

   rw_addr_form #(
      .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFS_W(OFS_W),
      .LEVELS(LEVELS), .ENT_SH(ENT_SH)
   ) u_addr (
      .vaddr(va_q), .level(lvl_q), .tbase(base_q), .ent_addr(ent_addr)
   );

   rw_entry_dec #(
      .ENT_W(ENT_W), .PA_W(PA_W), .OFS_W(OFS_W), .LEVELS(LEVELS),
      .PRES_BIT(PRES_BIT), .LARGE_BIT(LARGE_BIT), .LARGE_EN(1'b1),
      .LARGE_LO(1), .LARGE_HI(LEVELS-2)
   ) u_dec (
      .entry(mem_rsp_data), .level(lvl_q), .present(ent_present),
      .leaf(ent_leaf), .next_base(ent_next)
   );

   rw_phys_form #(
      .ENT_W(ENT_W), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W),
      .OFS_W(OFS_W), .LEVELS(LEVELS)
   ) u_phys (
      .entry(mem_rsp_data), .vaddr(va_q), .level(lvl_q), .paddr(leaf_pa)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= WK_IDLE;
         lvl_q      <= '0;
         base_q     <= '0;
         va_q       <= '0;
         res_pa_q   <= '0;
         res_size_q <= '0;
         res_lvl_q  <= '0;
         res_flg_q  <= '0;
      end else begin
         unique case (st_q)
            WK_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr[VA_W-1:0];
                  base_q <= root_base;
                  lvl_q  <= LVL_W'(LEVELS-1);
                  if (noncanon) begin
                     res_pa_q   <= '0;
                     res_size_q <= '0;
                     res_lvl_q  <= LVL_W'(LEVELS-1);
                     res_flg_q  <= '{fault: 1'b1, noncanon: 1'b1};
                     st_q       <= WK_DONE;
                  end else begin
                     st_q <= WK_ISSUE;
                  end
               end
            end
            WK_ISSUE: st_q <= WK_WAIT;
            WK_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     res_pa_q   <= '0;
                     res_size_q <= '0;
                     res_lvl_q  <= lvl_q;
                     res_flg_q  <= '{fault: 1'b1, noncanon: 1'b0};
                     st_q       <= WK_DONE;
                  end else if (ent_leaf) begin
                     res_pa_q   <= leaf_pa;
                     res_size_q <= lvl_q;
                     res_lvl_q  <= lvl_q;
                     res_flg_q  <= '0;
                     st_q       <= WK_DONE;
                  end else begin
                     base_q <= ent_next;
                     lvl_q  <= lvl_q - LVL_W'(1);
                     st_q   <= WK_ISSUE;
                  end
               end
            end
            WK_DONE: st_q <= WK_IDLE;
            default: st_q <= WK_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == WK_IDLE);
   assign mem_req_valid = (st_q == WK_ISSUE);
   assign mem_req_addr  = ent_addr;
   assign done          = (st_q == WK_DONE);
   assign done_paddr    = res_pa_q;
   assign done_size     = res_size_q;
   assign done_level    = res_lvl_q;
   assign done_fault    = res_flg_q.fault;
   assign done_noncanon = res_flg_q.noncanon;

endmodule

// File: rtl/radix_walk_chk.sv
module radix_walk_chk #(
   parameter int VA_IN_W = 64,
   parameter int VA_W    = 48,
   parameter int PA_W    = 52,
   parameter int LVL_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [VA_IN_W-1:0] req_vaddr,
   input logic               mem_req_valid,
   input logic [PA_W-1:0]    mem_req_addr,
   input logic               done,
   input logic [PA_W-1:0]    done_paddr,
   input logic [LVL_W-1:0]   done_size,
   input logic               done_fault,
   input logic               done_noncanon
);

   logic [VA_IN_W-VA_W:0] top_bits;
   logic                  bad_upper;

   assign top_bits  = req_vaddr[VA_IN_W-1:VA_W-1];
   assign bad_upper = !((&top_bits) || !(|top_bits));

   // R3: one-cycle read strobe, 8-byte aligned address
   a_r3_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   a_r3_addr_align: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
   // R1: no traffic and no result while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !done));
   // R10: result strobe lasts one cycle and frees the walker
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));
   a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_fault) |-> (done_paddr == '0 && done_size == '0));
   a_r10_nc_is_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_noncanon) |-> done_fault);
   // R8: no size code beyond 1 GB on success
   a_r8_size_code: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_fault) |-> (done_size != '1));
   // R9: bad upper bits finish at once without memory access
   a_r9_noncanon: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && bad_upper) |=> (done && done_fault && done_noncanon && !mem_req_valid));

endmodule

bind radix_walk radix_walk_chk #(
   .VA_IN_W(VA_IN_W), .VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_vaddr(req_vaddr), .mem_req_valid(mem_req_valid),
   .mem_req_addr(mem_req_addr), .done(done), .done_paddr(done_paddr),
   .done_size(done_size), .done_fault(done_fault),
   .done_noncanon(done_noncanon)
);

// File: tb/radix_walk_tb_top.sv
module radix_walk_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int PA_W = 52;
   localparam logic [63:0] FMASK = 64'h000F_FFFF_FFFF_F000;
   localparam logic [63:0] T4  = 64'h10_0000;
   localparam logic [63:0] T3  = 64'h10_1000;
   localparam logic [63:0] T2  = 64'h10_2000;
   localparam logic [63:0] T1  = 64'h10_3000;
   localparam logic [63:0] T3B = 64'h10_4000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [63:0]     req_vaddr = '0;
   logic [PA_W-1:0] root_base = '0;
   logic            mem_req_valid;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_rsp_valid = 1'b0;
   logic [63:0]     mem_rsp_data = '0;
   logic            done;
   logic [PA_W-1:0] done_paddr;
   logic [1:0]      done_size;
   logic            done_fault;
   logic            done_noncanon;
   logic [1:0]      done_level;

   radix_walk dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .root_base(root_base),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .done_paddr(done_paddr), .done_size(done_size),
      .done_fault(done_fault), .done_noncanon(done_noncanon),
      .done_level(done_level)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";
   int    rsp_delay = 0;
   bit    inject = 1'b0;

   logic [63:0]     pt [longint unsigned];
   longint unsigned q_addr [$];
   logic [63:0]     e_pa;
   int              e_size, e_lvl;
   bit              e_fault, e_nc;
   bit              m_busy = 1'b0;
   bit              e_ready = 1'b1;

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mkva(int i3, int i2, int i1, int i0, int off);
      logic [63:0] v;
      v = (64'(i3) << 39) | (64'(i2) << 30) | (64'(i1) << 21) | (64'(i0) << 12) | 64'(off);
      if (i3 >= 256) v = v | 64'hFFFF_0000_0000_0000;
      return v;
   endfunction

   // behavioural reference: full walk over the bench memory
   task automatic ref_walk(logic [63:0] va, logic [63:0] root);
      logic [63:0] base, e, a;
      int sh;
      q_addr.delete();
      e_pa = '0; e_size = 0; e_fault = 0; e_nc = 0; e_lvl = 3;
      if (!(va[63:47] == 17'h1FFFF || va[63:47] == 17'h0)) begin
         e_fault = 1; e_nc = 1;
         return;
      end
      base = root & FMASK;
      for (int lv = 3; lv >= 0; lv--) begin
         a = base + (((va >> (12 + 9*lv)) & 64'd511) << 3);
         q_addr.push_back(a);
         e = pt.exists(a) ? pt[a] : 64'd0;
         e_lvl = lv;
         if (!e[0]) begin
            e_fault = 1;
            return;
         end
         if (lv == 0 || (e[7] && (lv == 1 || lv == 2))) begin
            sh = 12 + 9*lv;
            e_pa = (((e & FMASK) >> sh) << sh) | (va & ((64'd1 << sh) - 64'd1));
            e_size = lv;
            return;
         end
         base = e & FMASK;
      end
   endtask

   // per-clock comparison against the model
   initial begin
      longint unsigned x;
      @(posedge rst_n);
      forever begin
         @(negedge clk); #1;
         chk(req_ready === e_ready, "R1", "req_ready", 64'(req_ready), 64'(e_ready));
         if (mem_req_valid) begin
            if (q_addr.size() == 0) chk(0, "R3", "unexpected read", 64'(mem_req_addr), 64'd0);
            else begin
               x = q_addr.pop_front();
               chk(64'(mem_req_addr) == x, "R3", "entry address", 64'(mem_req_addr), x);
            end
         end
         if (done) begin
            if (!m_busy) chk(0, "R10", "done while idle", 64'd1, 64'd0);
            else begin
               chk(q_addr.size() == 0, cur_req, "reads left", 64'(q_addr.size()), 64'd0);
               chk(done_fault == e_fault, cur_req, "fault", 64'(done_fault), 64'(e_fault));
               chk(done_noncanon == e_nc, cur_req, "noncanon", 64'(done_noncanon), 64'(e_nc));
               chk(32'(done_level) == e_lvl, cur_req, "level", 64'(done_level), 64'(e_lvl));
               chk(32'(done_size) == e_size, cur_req, "size", 64'(done_size), 64'(e_size));
               chk(64'(done_paddr) == (e_pa & 64'h000F_FFFF_FFFF_FFFF), cur_req, "paddr",
                   64'(done_paddr), e_pa);
            end
            m_busy = 0; e_ready = 1;
         end else if (req_ready && req_valid) begin
            ref_walk(req_vaddr, 64'(root_base));
            m_busy = 1; e_ready = 0;
         end
      end
   end

   // memory responder
   initial begin
      bit          pend;
      int          cnt;
      logic [63:0] pa_q;
      pend = 0; cnt = 0; pa_q = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_rsp_data  = 64'h0000_0000_5555_5000;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = pt.exists(pa_q) ? pt[pa_q] : 64'd0;
               pend = 0;
            end else cnt--;
         end else if (inject) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 64'h0000_0000_7777_7081;
         end
         if (mem_req_valid) begin
            pend = 1; cnt = rsp_delay; pa_q = 64'(mem_req_addr);
         end
      end
   end

   task automatic walk(logic [63:0] va, logic [63:0] root, int dly, string tag, bit hold_busy);
      cur_req = tag; rsp_delay = dly;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vaddr = va; root_base = root[PA_W-1:0]; req_valid = 1'b1;
      @(negedge clk);
      if (hold_busy) begin
         req_vaddr = mkva(5, 7, 9, 12, 0);
         @(negedge clk);
      end
      req_valid = 1'b0; req_vaddr = '0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      pt[T4 + 5*8]   = T3 | 64'h1;
      pt[T3 + 7*8]   = T2 | 64'h1;
      pt[T2 + 9*8]   = T1 | 64'h1;
      pt[T1 + 11*8]  = 64'h8000_0000_ABCD_E021;
      pt[T2 + 10*8]  = 64'h0000_0004_0021_E081;
      pt[T3 + 8*8]   = 64'h0000_0013_1234_5081;
      pt[T4 + 6*8]   = T3B | 64'h81;
      pt[T3B + 2*8]  = T2 | 64'h1;
      pt[T1 + 12*8]  = 64'h0000_000F_EDCB_B081;
      pt[T1 + 1*8]   = 64'h0000_0000_AAAA_A0FE;
      pt[T4 + 256*8] = T3 | 64'h1;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk(done === 1'b0, "R11", "done in reset", 64'(done), 64'd0);
      chk(mem_req_valid === 1'b0, "R11", "read in reset", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
      chk(done === 1'b0, "R11", "done after reset", 64'(done), 64'd0);

      walk(mkva(5, 7, 9, 11, 12'h123), T4, 0, "R8 R2", 0);
      walk(mkva(5, 7, 9, 11, 12'hFFF), T4, 3, "R4 R8", 0);
      walk(mkva(5, 7, 10, 9'h1A5, 12'h321), T4, 1, "R7", 0);
      walk(mkva(5, 8, 9'h155, 9'h0AA, 12'h777), T4, 2, "R6", 0);
      walk(mkva(6, 2, 9, 11, 12'h456), T4, 0, "R8", 0);
      walk(mkva(5, 7, 9, 12, 12'hFFF), T4, 5, "R8", 0);
      walk(mkva(0, 7, 9, 11, 0), T4, 0, "R5 R10", 0);
      walk(mkva(5, 0, 9, 11, 0), T4, 1, "R5 R10", 0);
      walk(mkva(5, 7, 0, 11, 0), T4, 0, "R5", 0);
      walk(mkva(5, 7, 9, 0, 0), T4, 2, "R5", 0);
      walk(mkva(5, 7, 9, 1, 12'h010), T4, 0, "R5 R10", 0);
      walk(mkva(256, 7, 9, 11, 12'h001), T4, 1, "R2", 0);
      walk(64'h0001_0000_0000_0000, T4, 0, "R9", 0);
      walk(64'hFFFF_0000_0000_1000, T4, 0, "R9", 0);
      walk(64'h0000_8000_0000_0000, T4, 0, "R9 R10", 0);
      walk(mkva(5, 7, 9, 11, 12'h0AB), T4 | 64'hABC, 1, "R3", 0);
      walk(mkva(5, 7, 10, 3, 12'h004), T4, 4, "R1", 1);

      // R4: stray responses while idle and between reads
      inject = 1'b1;
      repeat (5) @(negedge clk);
      walk(mkva(5, 7, 9, 11, 12'h5A5), T4, 2, "R4", 0);
      repeat (4) @(negedge clk);
      inject = 1'b0;
      repeat (3) @(negedge clk);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule